// File: doc/BRIEF.md
# Shutdown / Output-Enable Pin Control Decoder

This block turns a single external control pin into a drive state for every clock output of a clock generator. Two configuration bits decide what the pin means. A mode bit makes it either a chip-wide shutdown or an output enable. A polarity bit sets its active level, and the polarity matters only when the pin is an output enable. Each output also has two bits of its own. The first, a "slot enable" bit, tri-states the output when it is clear. The second, a "pin-controlled" bit, makes the output follow the pin. The block reports a 2-bit state code per output and a shutdown request to the PLL.

The pin is asynchronous and is passed through a two-flop synchronizer. The pin has a weak pull-down, so an unconnected pin reads as 0. Each output's clock level is sampled in the block's clock domain. An output that is running (code 00) changes state only when its clock has just fallen, so a disable never cuts a high phase short. Every other change of state takes effect at the next edge. The configuration bits are treated as quasi-static levels and are not synchronized. The drivers, and the idle levels they produce, lie outside this block: in shutdown, a differential driver parks as a complementary high/low pair and a single-ended driver drives low.

Top module: `pin_ctl_decoder`

## Requirements
- R1: While reset is low, and after it is released until the first update, every output code is 01 (tri-state) and `shutdown_req` is 0. The codes are 00 active, 01 tri-state, 10 parked, 11 shutdown, and output i uses bits [2i+1:2i] of `out_state`.
- R2: The pin level sampled at rising edge k reaches `shutdown_req` after edge k+1. It reaches the target state of the outputs at edge k+2.
- R3: With `cfg_sh`=1 and the synchronized pin at 1, `shutdown_req` is 1 and the target of every output is 11, whatever the other bits are. With `cfg_sh`=0, `shutdown_req` is always 0.
- R4: When shutdown is not in force, an output whose `out_os` bit is 0 targets 01, whatever its `out_oe` bit is.
- R5: When shutdown is not in force, an output with `out_os`=1 and `out_oe`=0 targets 00, whatever the pin is.
- R6: With `cfg_sh`=0 and both per-output bits at 1, an output targets 00 when the synchronized pin equals `cfg_sp`, and 10 otherwise. `cfg_sp`=0 means active low, so a floating pin enables.
- R7: With `cfg_sh`=1 and the pin at 0, an output with both bits at 1 targets 00, and `cfg_sp` has no effect.
- R8: An output in state 00 leaves it only at an edge where its `out_clk_lvl` was 1 at the previous edge and is 0 now. From any other state, an output moves to its target at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Raw external control pin, asynchronous |
| cfg_sh | input | 1 | 1: the pin is a shutdown; 0: the pin is an output enable |
| cfg_sp | input | 1 | Enable polarity: 0 active low, 1 active high |
| out_os | input | N_OUT | Per-output slot enable; 0 tri-states the output |
| out_oe | input | N_OUT | Per-output pin-controlled bit |
| out_clk_lvl | input | N_OUT | Sampled level of each output clock |
| out_state | output | 2*N_OUT | Per-output state code, 2 bits per output |
| shutdown_req | output | 1 | Global shutdown request to the PLL |

## Verification
`shutdown_req` is due one edge after the synchronizer's first stage samples the pin. A target state is due one edge later. For an output that is running, the new state is further held until the first edge at which its clock has fallen. The bench model keeps the raw pin in a queue, applies the pin level from two edges back, and applies the falling-edge gate from its own record of each clock level. It compares both outputs at every falling clock edge, after the posedge that produced them and before new stimulus. Directed checks pin the one-edge and two-edge delays and hold a clock high to show that an output which is running stays in 00.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;
  typedef enum logic [1:0] {
    ST_ACT  = 2'b00,
    ST_TRI  = 2'b01,
    ST_PARK = 2'b10,
    ST_SHUT = 2'b11
  } drv_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], async_in};
  end

  assign sync_out = chain[LAST];
endmodule

// File: rtl/pin_decode.sv
module pin_decode
  import pin_ctl_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic                  pin_s,
  input  logic                  sh,
  input  logic                  sp,
  input  logic [N_OUT-1:0]      os,
  input  logic [N_OUT-1:0]      oe,
  output drv_state_t            tgt [N_OUT],
  output logic                  shut
);
  logic enabled;

  assign shut    = sh & pin_s;
  assign enabled = sh | (pin_s == sp);

  for (genvar i = 0; i < N_OUT; i++) begin : g_dec
    always_comb begin
      if (shut)        tgt[i] = ST_SHUT;
      else if (!os[i]) tgt[i] = ST_TRI;
      else if (!oe[i]) tgt[i] = ST_ACT;
      else             tgt[i] = enabled ? ST_ACT : ST_PARK;
    end

    // R4
    always_comb begin
      tri_when_slot_off_chk: assert (shut || os[i] || tgt[i] == ST_TRI);
    end
  end

  // R3
  always_comb begin
    shut_only_in_sd_mode_chk: assert (sh || !shut);
  end
endmodule

// File: rtl/out_slot.sv
module out_slot
  import pin_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  drv_state_t tgt,
  input  logic       clk_lvl,
  output drv_state_t st
);
  logic prev_lvl;
  logic fell;

  assign fell = prev_lvl & ~clk_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_TRI;
      prev_lvl <= 1'b0;
    end else begin
      prev_lvl <= clk_lvl;
      if (st != tgt && (st != ST_ACT || fell)) st <= tgt;
    end
  end

  // R8
  active_held_until_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACT && !fell) |=> st == ST_ACT);

  // R8
  idle_moves_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_ACT) |=> st == $past(tgt));
endmodule

// File: rtl/pin_ctl_decoder.sv
module pin_ctl_decoder
  import pin_ctl_pkg::*;
#(
  parameter int N_OUT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_pin,
  input  logic               cfg_sh,
  input  logic               cfg_sp,
  input  logic [N_OUT-1:0]   out_os,
  input  logic [N_OUT-1:0]   out_oe,
  input  logic [N_OUT-1:0]   out_clk_lvl,
  output logic [2*N_OUT-1:0] out_state,
  output logic               shutdown_req
);
  logic       pin_s;
  drv_state_t tgt [N_OUT];

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ctl_pin), .sync_out(pin_s)
  );

  pin_decode #(.N_OUT(N_OUT)) u_dec (
    .pin_s(pin_s), .sh(cfg_sh), .sp(cfg_sp), .os(out_os), .oe(out_oe),
    .tgt(tgt), .shut(shutdown_req)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_slot
    drv_state_t st;
    out_slot u_slot (
      .clk(clk), .rst_n(rst_n), .tgt(tgt[i]), .clk_lvl(out_clk_lvl[i]), .st(st)
    );
    assign out_state[2*i +: 2] = st;
  end

  // R2
  if (SYNC_STAGES == 2) begin : g_lat_chk
    sd_two_edge_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(shutdown_req) && $stable(cfg_sh)) |-> $past(ctl_pin, 2));
  end

  // R3
  no_sd_in_enable_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sh |-> !shutdown_req);
endmodule

// File: tb/tb_pin_ctl_decoder.sv
module tb_pin_ctl_decoder;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_pin = 1'b0, cfg_sh = 1'b0, cfg_sp = 1'b0;
  logic [N-1:0] out_os = '0, out_oe = '0, out_clk_lvl = '0;
  logic [2*N-1:0] out_state;
  logic shutdown_req;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  bit hold_clk = 0;
  int phase = 0;

  logic q[$];
  logic [1:0] m_st [N];
  logic m_prev [N];
  logic m_sd;

  always #2.5 clk = ~clk;

  pin_ctl_decoder #(.N_OUT(N)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .cfg_sh(cfg_sh), .cfg_sp(cfg_sp),
    .out_os(out_os), .out_oe(out_oe), .out_clk_lvl(out_clk_lvl),
    .out_state(out_state), .shutdown_req(shutdown_req)
  );

  function automatic logic [1:0] exp_tgt(logic sh, logic sp, logic os, logic oe, logic p);
    if (sh && p) return 2'b11;
    if (!os)     return 2'b01;
    if (!oe)     return 2'b00;
    if (sh)      return 2'b00;
    return (p == sp) ? 2'b00 : 2'b10;
  endfunction

  function automatic string tag_of(logic sh, logic os, logic oe, logic p);
    if (sh && p) return "R3";
    if (!os)     return "R4";
    if (!oe)     return "R5";
    if (sh)      return "R7";
    return "R6";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    q.push_back(1'b0);
    q.push_back(1'b0);
    for (int i = 0; i < N; i++) begin m_st[i] = 2'b01; m_prev[i] = 1'b0; end
    m_sd = 1'b0;
  endtask

  task automatic tick();
    logic d;
    logic [1:0] t;
    @(posedge clk);
    q.push_back(ctl_pin);
    d = q[0];
    for (int i = 0; i < N; i++) begin
      t = exp_tgt(cfg_sh, cfg_sp, out_os[i], out_oe[i], d);
      if (m_st[i] != t && (m_st[i] != 2'b00 || (m_prev[i] && !out_clk_lvl[i])))
        m_st[i] = t;
      m_prev[i] = out_clk_lvl[i];
    end
    void'(q.pop_front());
    m_sd = cfg_sh & q[0];
    @(negedge clk);
    for (int i = 0; i < N; i++)
      check({tag_of(cfg_sh, out_os[i], out_oe[i], d), "/R8 state"},
            32'(out_state[2*i +: 2]), 32'(m_st[i]));
    check("R3 shutdown_req", 32'(shutdown_req), 32'(m_sd));
    phase++;
    if (!hold_clk) begin
      out_clk_lvl[0] = ~out_clk_lvl[0];
      if (phase % 2 == 0) out_clk_lvl[1] = ~out_clk_lvl[1];
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset state", 32'(out_state), 32'(4'b0101));
    check("R1 reset shutdown_req", 32'(shutdown_req), 32'd0);
    rst_n = 1'b1;

    // Exhaustive sweep of mode, polarity, per-output bits and pin
    for (int c = 0; c < 32; c++) begin
      cfg_sh = c[4]; cfg_sp = c[3];
      out_os = {~c[2], c[2]};
      out_oe = {c[1] ^ c[2], c[1]};
      ctl_pin = c[0];
      repeat (8) tick();
    end

    // R2 latency of shutdown_req
    cfg_sh = 1; cfg_sp = 0; out_os = '1; out_oe = '1; ctl_pin = 0;
    repeat (6) tick();
    ctl_pin = 1;
    tick();
    check("R2 sd not yet after first edge", 32'(shutdown_req), 32'd0);
    tick();
    check("R2 sd after second edge", 32'(shutdown_req), 32'd1);
    repeat (6) tick();
    check("R3 all outputs shut", 32'(out_state), 32'(4'b1111));

    // R6 default polarity: floating pin enables
    cfg_sh = 0; cfg_sp = 0; ctl_pin = 0;
    repeat (6) tick();
    check("R6 low pin enables", 32'(out_state), 32'(4'b0000));

    // R8 hold clock high: active output must not leave 00
    out_clk_lvl = '1; hold_clk = 1;
    tick();
    ctl_pin = 1;
    repeat (6) tick();
    check("R8 held while clock high", 32'(out_state), 32'(4'b0000));
    out_clk_lvl = '0;
    tick();
    check("R8 parks at falling level", 32'(out_state), 32'(4'b1010));
    hold_clk = 0;

    // R7 polarity ignored in shutdown mode with pin low
    cfg_sh = 1; cfg_sp = 1; ctl_pin = 0;
    repeat (8) tick();
    check("R7 sp ignored in sd mode", 32'(out_state), 32'(4'b0000));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule